// File: doc/BRIEF.md
# Collision and Deferral Event Counter

This block keeps four small event counters for a transmit path. It counts single collisions, multiple collisions, deferred transmits and excessively deferred transmits. The MAC raises a one-cycle pulse on one event line for each occurrence. The four counts are packed into one status word.

The host reads the word through a single read strobe. That read captures the four counts and clears them. When any counter passes its maximum and wraps to zero, a sticky rollover flag is set. The flag stays set until the next read. While a separate enable input is high, the flag drives an interrupt request. This lets software collect the counts before more wraps lose information.

Top module: `coll_stat_counter`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `rd_data_o` is 0, `roll_flag_o` is 0 and `irq_o` is 0.
- R2: Each counter advances by exactly one for each clock edge at which its event bit is high. Counters do not affect each other. Event bit i counts into field bits [4i+3:4i] of the word:
  - bit 0: single collision
  - bit 1: multiple collision
  - bit 2: deferred
  - bit 3: excessively deferred
- R3: After a clock edge at which `rd_stb_i` is high, `rd_data_o` holds the packed counts as they stood before that edge. `rd_data_o` keeps that value until the next read.
- R4: The clock edge that samples `rd_stb_i` high also sets every counter and the rollover flag to zero.
- R5: An event that arrives at the same edge as a read is counted into the cleared counter. The next read then shows 1 in that field.
- R6: A counter at 15 that receives an event wraps to 0. At that same edge `roll_flag_o` rises.
- R7: `roll_flag_o` stays high through idle cycles and further events until a read clears it.
- R8: `irq_o` is a registered output. After each edge it equals the flag state after that edge ANDed with `irq_en_i` as sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | LANES | One-cycle event pulses, one bit per counter |
| rd_stb_i | input | 1 | Host read strobe: capture and clear |
| irq_en_i | input | 1 | Rollover interrupt enable |
| rd_data_o | output | LANES*CNT_W | Packed counts captured by the last read |
| roll_flag_o | output | 1 | Sticky rollover status |
| irq_o | output | 1 | Rollover interrupt request |

## Verification
The bench builds the block with its default parameters: four counters of 4 bits each. At that size the whole count range of every counter is reachable in a few cycles. For each counter in turn, the bench applies every pulse count from 0 to 17, which covers both sides of the wrap and the flag rising on the sixteenth event. It also checks these cases:
- all 16 event masks applied together, giving 8 in every field;
- a read that coincides with events on every line;
- the flag with the interrupt enable off, then toggled on and off.

// File: rtl/coll_stat_pkg.sv
package coll_stat_pkg;
  // default geometry: four counters of four bits, one 16-bit word
  localparam int unsigned LANES_DEF = 4;
  localparam int unsigned CNT_W_DEF = 4;
endpackage

// File: rtl/coll_nibble_cnt.sv
module coll_nibble_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  // a wrap only happens on a real increment past the top value
  always_comb wrap_o = inc_i & ~clr_i & (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= inc_i ? CNT_ONE : '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/coll_roll_flag.sv
module coll_roll_flag #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] wrap_i,
  input  logic             clr_i,
  input  logic             irq_en_i,
  output logic             flag_o,
  output logic             irq_o
);
  logic flag_q, flag_d, irq_q;

  always_comb begin
    if (clr_i) flag_d = 1'b0;
    else       flag_d = flag_q | (|wrap_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & irq_en_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/coll_stat_counter.sv
module coll_stat_counter #(
  parameter int unsigned LANES = coll_stat_pkg::LANES_DEF,
  parameter int unsigned CNT_W = coll_stat_pkg::CNT_W_DEF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       evt_i,
  input  logic                   rd_stb_i,
  input  logic                   irq_en_i,
  output logic [LANES*CNT_W-1:0] rd_data_o,
  output logic                   roll_flag_o,
  output logic                   irq_o
);
  localparam int unsigned WORD_W = LANES * CNT_W;

  logic [WORD_W-1:0] cnt_flat;
  logic [LANES-1:0]  lane_wrap;
  logic [WORD_W-1:0] rd_data_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    coll_nibble_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .clr_i  (rd_stb_i),
      .inc_i  (evt_i[g]),
      .cnt_o  (cnt_flat[g*CNT_W +: CNT_W]),
      .wrap_o (lane_wrap[g])
    );
  end

  coll_roll_flag #(.LANES(LANES)) u_roll (
    .clk      (clk),
    .rst      (rst),
    .wrap_i   (lane_wrap),
    .clr_i    (rd_stb_i),
    .irq_en_i (irq_en_i),
    .flag_o   (roll_flag_o),
    .irq_o    (irq_o)
  );

  // snapshot register: loaded only by a read, held otherwise
  always_ff @(posedge clk) begin
    if (rst)           rd_data_q <= '0;
    else if (rd_stb_i) rd_data_q <= cnt_flat;
  end

  assign rd_data_o = rd_data_q;
endmodule

// File: rtl/coll_stat_counter_chk.sv
module coll_stat_counter_chk #(
  parameter int unsigned LANES = 4,
  parameter int unsigned CNT_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [LANES-1:0]       evt_i,
  input logic                   rd_stb_i,
  input logic [LANES*CNT_W-1:0] rd_data_o,
  input logic                   roll_flag_o,
  input logic                   irq_o,
  input logic [LANES*CNT_W-1:0] cnt_flat
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R3: a read captures the pre-edge counts
  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    rd_stb_i |=> rd_data_o == $past(cnt_flat));

  // R3: without a read the snapshot holds
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_stb_i |=> $stable(rd_data_o));

  // R4: a read clears the flag
  p_flag_clear_r4: assert property (@(posedge clk) disable iff (rst)
    rd_stb_i |=> !roll_flag_o);

  // R7: the flag is sticky while no read occurs
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (roll_flag_o && !rd_stb_i) |=> roll_flag_o);

  // R8: a request is never raised without the flag
  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> roll_flag_o);

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    // R2: one step per event
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
      !rd_stb_i |=> cnt_flat[i*CNT_W +: CNT_W] ==
        ($past(cnt_flat[i*CNT_W +: CNT_W]) + {{(CNT_W-1){1'b0}}, $past(evt_i[i])}));

    // R4, R5: a read leaves only a coincident event
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
      rd_stb_i |=> cnt_flat[i*CNT_W +: CNT_W] == {{(CNT_W-1){1'b0}}, $past(evt_i[i])});

    // R6: a wrap raises the flag at the same edge
    p_wrap_flag_r6: assert property (@(posedge clk) disable iff (rst)
      (!rd_stb_i && evt_i[i] && cnt_flat[i*CNT_W +: CNT_W] == CNT_MAX) |=> roll_flag_o);
  end
endmodule

bind coll_stat_counter coll_stat_counter_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .evt_i       (evt_i),
  .rd_stb_i    (rd_stb_i),
  .rd_data_o   (rd_data_o),
  .roll_flag_o (roll_flag_o),
  .irq_o       (irq_o),
  .cnt_flat    (cnt_flat)
);

// File: tb/coll_stat_counter_tb.sv
`timescale 1ns/1ps
module coll_stat_counter_tb;
  localparam int LANES  = 4;
  localparam int CNT_W  = 4;
  localparam int WORD_W = LANES * CNT_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [LANES-1:0]  evt = '0;
  logic              rd_stb = 1'b0;
  logic              irq_en = 1'b0;
  logic [WORD_W-1:0] rd_data;
  logic              roll_flag;
  logic              irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  coll_stat_counter #(.LANES(LANES), .CNT_W(CNT_W)) u_dut (
    .clk (clk), .rst (rst), .evt_i (evt), .rd_stb_i (rd_stb),
    .irq_en_i (irq_en), .rd_data_o (rd_data),
    .roll_flag_o (roll_flag), .irq_o (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; applies inputs across one rising edge
  task automatic cycle(input logic [LANES-1:0] m, input logic rd);
    evt = m; rd_stb = rd;
    @(negedge clk);
    evt = '0; rd_stb = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 data in reset", 32'(rd_data), 32'h0);
    check("R1 flag in reset", 32'(roll_flag), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 data after reset", 32'(rd_data), 32'h0);
    check("R1 flag after reset", 32'(roll_flag), 32'h0);
    check("R1 irq after reset", 32'(irq), 32'h0);

    // exhaustive per-counter sweep across the wrap point
    irq_en = 1'b1;
    for (int lane = 0; lane < LANES; lane++) begin
      for (int n = 0; n < 18; n++) begin
        for (int p = 0; p < n; p++) cycle(LANES'(1 << lane), 1'b0);
        check("R6 flag after n events", 32'(roll_flag), 32'(n >= 16));
        check("R8 irq follows flag", 32'(irq), 32'(n >= 16));
        cycle('0, 1'b1);
        check("R2 R3 read value", 32'(rd_data), 32'((n % 16) << (CNT_W * lane)));
        check("R4 flag cleared", 32'(roll_flag), 32'h0);
        check("R8 irq cleared", 32'(irq), 32'h0);
        cycle('0, 1'b1);
        check("R4 counts cleared", 32'(rd_data), 32'h0);
      end
    end

    // all masks once: every counter sees 8 events
    for (int m = 0; m < 16; m++) cycle(LANES'(m), 1'b0);
    cycle('0, 1'b1);
    check("R2 mixed masks", 32'(rd_data), 32'h8888);

    // read coinciding with events
    for (int p = 0; p < 5; p++) cycle(4'h1, 1'b0);
    cycle(4'hF, 1'b1);
    check("R5 value before coincident read", 32'(rd_data), 32'h0005);
    cycle('0, 1'b1);
    check("R5 coincident events kept", 32'(rd_data), 32'h1111);

    // snapshot holds while counting continues
    for (int p = 0; p < 3; p++) cycle(4'h3, 1'b0);
    check("R3 snapshot held", 32'(rd_data), 32'h1111);
    cycle('0, 1'b1);
    check("R3 new snapshot", 32'(rd_data), 32'h0033);

    // gating and stickiness
    irq_en = 1'b0;
    for (int p = 0; p < 16; p++) cycle(4'h8, 1'b0);
    check("R6 flag on wrap", 32'(roll_flag), 32'h1);
    check("R8 irq masked", 32'(irq), 32'h0);
    for (int p = 0; p < 4; p++) cycle('0, 1'b0);
    check("R7 flag sticky", 32'(roll_flag), 32'h1);
    irq_en = 1'b1;
    cycle('0, 1'b0);
    check("R8 irq on enable", 32'(irq), 32'h1);
    irq_en = 1'b0;
    cycle('0, 1'b0);
    check("R8 irq off on disable", 32'(irq), 32'h0);
    check("R7 flag still set", 32'(roll_flag), 32'h1);
    irq_en = 1'b1;
    cycle('0, 1'b1);
    check("R6 wrapped field reads zero", 32'(rd_data), 32'h0);
    check("R4 flag cleared by read", 32'(roll_flag), 32'h0);
    check("R8 irq after read", 32'(irq), 32'h0);

    done = 1'b1;
    summary();
  end
endmodule